// File: doc/BRIEF.md
# SMRAM and TSEG Window Decoder

This block sits in a host bridge and routes every memory access that touches the system-management memory windows. Two eight-bit control registers set the routing. The first holds the open, lock and global-enable controls. The second holds the high-alias enable, the TSEG enable and a TSEG size code. Each access arrives with a physical address and an attribute that marks whether the processor is in system-management mode (SMM). One cycle later the block returns a routing decision: legacy video space, DRAM, a black hole, or pass-through to the normal decode.

Three windows are decoded:
- A 128 KB low window at 0x000A0000.
- A 128 KB high alias at 0xFEDA0000, which is redirected onto the DRAM behind the low window.
- A TSEG range that sits directly below the configured top of low memory.

Once the lock bit is set, both registers are frozen and the open control is held at zero. Only a reset releases the lock. The DRAM and PCI back ends are not part of this block. They receive only the target code and the address that goes with it.

Top module: `smram_tseg_decoder`

## Requirements
- R1: After reset, both control registers read 0x00 and the lock bit is clear. The lock bit never returns to 0 except through reset.
- R2: Register fields are placed as follows, and all other bits always read 0.
  - First register (`reg_wr_sel`=0): bit0 = open, bit1 = lock, bit2 = global enable.
  - Second register (`reg_wr_sel`=1): bit0 = TSEG enable, bits[2:1] = size code, bit3 = high enable.
- R3: When a register update leaves the lock bit at 1, the open bit reads 0, and this holds in that same update. While the lock is set, writes to either register change nothing.
- R4: A non-SMM access to 0xA0000–0xBFFFF goes to DRAM when open=1 and high enable=0. Otherwise it goes to video.
- R5: A non-SMM access to 0xFEDA0000–0xFEDBFFFF goes to DRAM only when open=1 and high enable=1. In that case the address is remapped to 0x000A0000 plus the offset. Otherwise the access passes through unchanged.
- R6: For SMM accesses, routing depends on global enable and high enable.
  - Global enable=1, high enable=0: the low window goes to DRAM and the high alias passes through.
  - Global enable=1, high enable=1: the high alias goes to DRAM with the address remapped, and the low window goes to video.
  - Global enable=0: the low window goes to video and the high alias passes through.
- R7: TSEG size depends on the size code: code 0 is 1 MB, code 1 is 2 MB, and code 2 is 8 MB. Code 3, or TSEG enable=0, gives a size of 0. TSEG covers [MEM_TOP − size, MEM_TOP).
- R8: A non-SMM access that hits TSEG gets target code 3, which is the black hole.
  - A read returns `rsp_rdata`=0xFFFFFFFF.
  - A write asserts `rsp_wdrop`.
  - An SMM access that hits TSEG goes to DRAM.
  - For every other access, `rsp_rdata` is 0 and `rsp_wdrop` is 0.
- R9: Each response appears one cycle after its request, with `rsp_vld` set.
  - The target codes are pass=0, video=1, DRAM=2 and hole=3.
  - An address outside all windows passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | 0 = first control register, 1 = second control register |
| reg_wr_data | input | 8 | Register write data |
| ctl_q | output | 8 | Current value of the first control register |
| ext_q | output | 8 | Current value of the second control register |
| acc_vld | input | 1 | Access request valid |
| acc_smm | input | 1 | Access is issued in SMM |
| acc_wr | input | 1 | Access is a write |
| acc_addr | input | 32 | Physical address of the access |
| rsp_vld | output | 1 | Routing decision valid |
| rsp_tgt | output | 2 | Target code |
| rsp_addr | output | 32 | Address forwarded to the target |
| rsp_rdata | output | 32 | Fill data for a black-holed read |
| rsp_wdrop | output | 1 | Write is discarded |

## Verification
The assertions assume three things about the configuration:
- `MEM_TOP` is at least 8 MB.
- The TSEG range does not overlap the low window or the high alias.
- Reset is applied before the first access.

The bench keeps `MEM_TOP` at its 2 GB default and drives the register strobe and the access strobe on separate cycles, so every access sees settled register values. It programs the locked configurations only after all of the table-driven accesses have finished, because a lock cannot be undone without a reset.

// File: rtl/smram_pkg.sv
package smram_pkg;

    localparam int ADDR_W = 32;
    localparam int REG_W  = 8;

    typedef enum logic [1:0] {
        TGT_PASS  = 2'd0,
        TGT_VIDEO = 2'd1,
        TGT_DRAM  = 2'd2,
        TGT_HOLE  = 2'd3
    } tgt_e;

    // first register bit positions
    localparam int CB_OPEN = 0;
    localparam int CB_LOCK = 1;
    localparam int CB_GEN  = 2;
    // second register bit positions
    localparam int EB_TEN  = 0;
    localparam int EB_TSZ  = 1;
    localparam int EB_HEN  = 3;

    localparam logic [REG_W-1:0] CTL_RST       = 8'h00;
    localparam logic [REG_W-1:0] EXT_RST       = 8'h00;
    localparam logic [REG_W-1:0] CTL_WMASK     = 8'h07;
    localparam logic [REG_W-1:0] EXT_WMASK     = 8'h0F;
    localparam logic [REG_W-1:0] CTL_WMASK_LCK = 8'h00;
    localparam logic [REG_W-1:0] EXT_WMASK_LCK = 8'h00;

    localparam logic [ADDR_W-1:0] LOW_BASE  = 32'h000A_0000;
    localparam logic [ADDR_W-1:0] HIGH_BASE = 32'hFEDA_0000;
    localparam logic [ADDR_W-1:0] WIN_SPAN  = 32'h0002_0000;
    localparam logic [ADDR_W-1:0] HOLE_FILL = 32'hFFFF_FFFF;

    typedef struct packed {
        logic       win_open;
        logic       smm_en;
        logic       high_en;
        logic       tseg_en;
        logic [1:0] tseg_code;
    } smram_cfg_t;

    typedef struct packed {
        tgt_e              tgt;
        logic [ADDR_W-1:0] addr;
    } route_t;

    function automatic smram_cfg_t unpack_cfg(input logic [REG_W-1:0] ctl,
                                              input logic [REG_W-1:0] ext);
        smram_cfg_t c;
        c.win_open  = ctl[CB_OPEN];
        c.smm_en    = ctl[CB_GEN];
        c.high_en   = ext[EB_HEN];
        c.tseg_en   = ext[EB_TEN];
        c.tseg_code = ext[EB_TSZ +: 2];
        return c;
    endfunction

    function automatic logic [ADDR_W-1:0] tseg_bytes(input smram_cfg_t c);
        logic [ADDR_W-1:0] s;
        if (!c.tseg_en) begin
            s = '0;
        end else begin
            case (c.tseg_code)
                2'd0:    s = 32'h0010_0000;
                2'd1:    s = 32'h0020_0000;
                2'd2:    s = 32'h0080_0000;
                default: s = '0;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/smram_regs.sv
module smram_regs
    import smram_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] ctl_q,
    output logic [REG_W-1:0] ext_q
);
    logic [REG_W-1:0] ctl_mask, ext_mask, ctl_nx, ext_nx;
    logic             locked;

    assign locked   = ctl_q[CB_LOCK];
    assign ctl_mask = locked ? CTL_WMASK_LCK : CTL_WMASK;
    assign ext_mask = locked ? EXT_WMASK_LCK : EXT_WMASK;

    always_comb begin
        ctl_nx = ctl_q;
        ext_nx = ext_q;
        if (wr_en && !wr_sel)
            ctl_nx = (ctl_q & ~ctl_mask) | (wr_data & ctl_mask);
        if (wr_en && wr_sel)
            ext_nx = (ext_q & ~ext_mask) | (wr_data & ext_mask);
        if (ctl_nx[CB_LOCK])
            ctl_nx[CB_OPEN] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= CTL_RST;
            ext_q <= EXT_RST;
        end else begin
            ctl_q <= ctl_nx;
            ext_q <= ext_nx;
        end
    end
endmodule

// File: rtl/smram_addr_dec.sv
module smram_addr_dec
    import smram_pkg::*;
#(
    parameter logic [ADDR_W-1:0] MEM_TOP = 32'h8000_0000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              smm,
    input  smram_cfg_t        cfg,
    output route_t            route
);
    logic [ADDR_W-1:0] low_off, high_off, tsz;
    logic              low_hit, high_hit, tseg_hit;

    assign low_off  = addr - LOW_BASE;
    assign high_off = addr - HIGH_BASE;
    assign low_hit  = low_off < WIN_SPAN;
    assign high_hit = high_off < WIN_SPAN;
    assign tsz      = tseg_bytes(cfg);
    assign tseg_hit = (tsz != '0) && (addr < MEM_TOP) && (addr >= MEM_TOP - tsz);

    always_comb begin
        route.tgt  = TGT_PASS;
        route.addr = addr;
        if (low_hit) begin
            if (smm)
                route.tgt = (cfg.smm_en && !cfg.high_en) ? TGT_DRAM : TGT_VIDEO;
            else
                route.tgt = (cfg.win_open && !cfg.high_en) ? TGT_DRAM : TGT_VIDEO;
        end else if (high_hit) begin
            if (smm ? (cfg.smm_en && cfg.high_en) : (cfg.win_open && cfg.high_en)) begin
                route.tgt  = TGT_DRAM;
                route.addr = LOW_BASE + high_off;
            end
        end else if (tseg_hit) begin
            route.tgt = smm ? TGT_DRAM : TGT_HOLE;
        end
    end
endmodule

// File: rtl/smram_tseg_decoder.sv
module smram_tseg_decoder
    import smram_pkg::*;
#(
    parameter logic [31:0] MEM_TOP = 32'h8000_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr_en,
    input  logic        reg_wr_sel,
    input  logic [7:0]  reg_wr_data,
    output logic [7:0]  ctl_q,
    output logic [7:0]  ext_q,
    input  logic        acc_vld,
    input  logic        acc_smm,
    input  logic        acc_wr,
    input  logic [31:0] acc_addr,
    output logic        rsp_vld,
    output logic [1:0]  rsp_tgt,
    output logic [31:0] rsp_addr,
    output logic [31:0] rsp_rdata,
    output logic        rsp_wdrop
);
    smram_cfg_t cfg;
    route_t     route;
    logic       is_hole;

    smram_regs regs_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr_en),
        .wr_sel  (reg_wr_sel),
        .wr_data (reg_wr_data),
        .ctl_q   (ctl_q),
        .ext_q   (ext_q)
    );

    assign cfg = unpack_cfg(ctl_q, ext_q);

    smram_addr_dec #(.MEM_TOP(MEM_TOP)) dec_i (
        .addr  (acc_addr),
        .smm   (acc_smm),
        .cfg   (cfg),
        .route (route)
    );

    assign is_hole = acc_vld && (route.tgt == TGT_HOLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_vld   <= 1'b0;
            rsp_tgt   <= TGT_PASS;
            rsp_addr  <= '0;
            rsp_rdata <= '0;
            rsp_wdrop <= 1'b0;
        end else begin
            rsp_vld   <= acc_vld;
            rsp_tgt   <= acc_vld ? route.tgt : TGT_PASS;
            rsp_addr  <= acc_vld ? route.addr : '0;
            rsp_rdata <= (is_hole && !acc_wr) ? HOLE_FILL : '0;
            rsp_wdrop <= is_hole && acc_wr;
        end
    end
endmodule

// File: rtl/smram_tseg_decoder_chk.sv
module smram_tseg_decoder_chk (
    input logic        clk,
    input logic        rst,
    input logic [7:0]  ctl_q,
    input logic [7:0]  ext_q,
    input logic        acc_vld,
    input logic        acc_smm,
    input logic        rsp_vld,
    input logic [1:0]  rsp_tgt,
    input logic [31:0] rsp_rdata,
    input logic        rsp_wdrop
);
    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (ctl_q[7:3] == 5'd0) && (ext_q[7:4] == 4'd0));

    p_lock_closes_r3: assert property (@(posedge clk) disable iff (rst)
        ctl_q[1] |-> !ctl_q[0]);

    p_lock_sticky_r1: assert property (@(posedge clk) disable iff (rst)
        ctl_q[1] |=> ctl_q[1]);

    p_lock_freeze_r3: assert property (@(posedge clk) disable iff (rst)
        ctl_q[1] |=> ($stable(ext_q) && $stable(ctl_q)));

    p_rsp_follows_req_r9: assert property (@(posedge clk) disable iff (rst)
        acc_vld |=> rsp_vld);

    p_no_spurious_rsp_r9: assert property (@(posedge clk) disable iff (rst)
        !acc_vld |=> !rsp_vld);

    p_hole_fill_r8: assert property (@(posedge clk) disable iff (rst)
        (rsp_vld && rsp_tgt == 2'd3) |-> (rsp_wdrop || rsp_rdata == 32'hFFFF_FFFF));

    p_no_fill_elsewhere_r8: assert property (@(posedge clk) disable iff (rst)
        (rsp_tgt != 2'd3) |-> (!rsp_wdrop && rsp_rdata == 32'd0));

    p_smm_no_hole_r8: assert property (@(posedge clk) disable iff (rst)
        (acc_vld && acc_smm) |=> (rsp_tgt != 2'd3));
endmodule

bind smram_tseg_decoder smram_tseg_decoder_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .ctl_q     (ctl_q),
    .ext_q     (ext_q),
    .acc_vld   (acc_vld),
    .acc_smm   (acc_smm),
    .rsp_vld   (rsp_vld),
    .rsp_tgt   (rsp_tgt),
    .rsp_rdata (rsp_rdata),
    .rsp_wdrop (rsp_wdrop)
);

// File: tb/smram_tseg_decoder_tb_top.sv
`timescale 1ns/1ps
module smram_tseg_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic        reg_wr_sel = 1'b0;
    logic [7:0]  reg_wr_data = 8'h00;
    logic [7:0]  ctl_q, ext_q;
    logic        acc_vld = 1'b0;
    logic        acc_smm = 1'b0;
    logic        acc_wr = 1'b0;
    logic [31:0] acc_addr = 32'h0;
    logic        rsp_vld;
    logic [1:0]  rsp_tgt;
    logic [31:0] rsp_addr, rsp_rdata;
    logic        rsp_wdrop;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    smram_tseg_decoder dut_i (.*);

    typedef struct packed {
        logic [3:0]  req;
        logic [7:0]  ctl;
        logic [7:0]  ext;
        logic        smm;
        logic        wr;
        logic [31:0] addr;
        logic [1:0]  tgt;
        logic [31:0] oaddr;
    } vec_t;

    localparam int NV = 21;
    // targets: 0 pass, 1 video, 2 dram, 3 hole. ctl: b0 open, b1 lock, b2 gen. ext: b0 ten, b2:1 code, b3 hen
    localparam vec_t VECS [NV] = '{
        '{4'd4, 8'h00, 8'h00, 1'b0, 1'b0, 32'h000A_0000, 2'd1, 32'h000A_0000}, // R4 closed
        '{4'd6, 8'h04, 8'h00, 1'b1, 1'b0, 32'h000B_0000, 2'd2, 32'h000B_0000}, // R6 low dram
        '{4'd6, 8'h04, 8'h08, 1'b1, 1'b0, 32'h000A_1234, 2'd1, 32'h000A_1234}, // R6 low hidden
        '{4'd6, 8'h04, 8'h08, 1'b1, 1'b1, 32'hFEDA_1234, 2'd2, 32'h000A_1234}, // R6 high remap
        '{4'd6, 8'h00, 8'h08, 1'b1, 1'b0, 32'hFEDA_0010, 2'd0, 32'hFEDA_0010}, // R6 gen clear
        '{4'd6, 8'h00, 8'h00, 1'b1, 1'b0, 32'h000A_0000, 2'd1, 32'h000A_0000}, // R6 gen clear low
        '{4'd6, 8'h04, 8'h00, 1'b1, 1'b0, 32'hFEDA_0000, 2'd0, 32'hFEDA_0000}, // R6 hen clear high
        '{4'd4, 8'h01, 8'h00, 1'b0, 1'b0, 32'h000B_FFFF, 2'd2, 32'h000B_FFFF}, // R4 open
        '{4'd4, 8'h01, 8'h08, 1'b0, 1'b0, 32'h000A_0000, 2'd1, 32'h000A_0000}, // R4 open+hen
        '{4'd5, 8'h01, 8'h08, 1'b0, 1'b0, 32'hFEDB_FFFF, 2'd2, 32'h000B_FFFF}, // R5 open high
        '{4'd5, 8'h00, 8'h08, 1'b0, 1'b0, 32'hFEDA_0000, 2'd0, 32'hFEDA_0000}, // R5 closed high
        '{4'd5, 8'h05, 8'h00, 1'b0, 1'b0, 32'hFEDA_0004, 2'd0, 32'hFEDA_0004}, // R5 open no hen
        '{4'd8, 8'h00, 8'h01, 1'b0, 1'b0, 32'h7FF0_0000, 2'd3, 32'h7FF0_0000}, // R8 1MB read
        '{4'd7, 8'h00, 8'h01, 1'b0, 1'b0, 32'h7FEF_FFFF, 2'd0, 32'h7FEF_FFFF}, // R7 below 1MB
        '{4'd8, 8'h00, 8'h03, 1'b0, 1'b1, 32'h7FE0_0000, 2'd3, 32'h7FE0_0000}, // R8 2MB write
        '{4'd8, 8'h00, 8'h05, 1'b1, 1'b0, 32'h7F80_0000, 2'd2, 32'h7F80_0000}, // R8 smm tseg
        '{4'd7, 8'h00, 8'h05, 1'b0, 1'b0, 32'h7FFF_FFFF, 2'd3, 32'h7FFF_FFFF}, // R7 8MB top
        '{4'd7, 8'h00, 8'h07, 1'b0, 1'b0, 32'h7FFF_FFFF, 2'd0, 32'h7FFF_FFFF}, // R7 code3
        '{4'd7, 8'h00, 8'h04, 1'b0, 1'b0, 32'h7FFF_FFFF, 2'd0, 32'h7FFF_FFFF}, // R7 ten clear
        '{4'd9, 8'h00, 8'h05, 1'b0, 1'b0, 32'h8000_0000, 2'd0, 32'h8000_0000}, // R9 above top
        '{4'd9, 8'h05, 8'h08, 1'b1, 1'b1, 32'h0009_FFFF, 2'd0, 32'h0009_FFFF}  // R9 below low
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic access(input logic smm, input logic wr, input logic [31:0] a);
        @(negedge clk);
        acc_vld = 1'b1; acc_smm = smm; acc_wr = wr; acc_addr = a;
        @(negedge clk);
        acc_vld = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        do_reset();
        chk(ctl_q == 8'h00, "R1", "ctl reset", {24'h0, ctl_q}, 32'h0);
        chk(ext_q == 8'h00, "R1", "ext reset", {24'h0, ext_q}, 32'h0);
        chk(rsp_vld == 1'b0, "R9", "rsp_vld idle", {31'h0, rsp_vld}, 32'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [31:0] exp_rd;
            logic        exp_wd;
            string       rq;
            rq = $sformatf("R%0d", VECS[i].req);
            reg_write(1'b0, VECS[i].ctl);
            reg_write(1'b1, VECS[i].ext);
            access(VECS[i].smm, VECS[i].wr, VECS[i].addr);
            exp_rd = (VECS[i].tgt == 2'd3 && !VECS[i].wr) ? 32'hFFFF_FFFF : 32'h0;
            exp_wd = (VECS[i].tgt == 2'd3) && VECS[i].wr;
            chk(rsp_vld == 1'b1, rq, $sformatf("vec%0d vld", i), {31'h0, rsp_vld}, 32'h1);
            chk(rsp_tgt == VECS[i].tgt, rq, $sformatf("vec%0d tgt", i),
                {30'h0, rsp_tgt}, {30'h0, VECS[i].tgt});
            chk(rsp_addr == VECS[i].oaddr, rq, $sformatf("vec%0d addr", i), rsp_addr, VECS[i].oaddr);
            chk(rsp_rdata == exp_rd, rq, $sformatf("vec%0d rdata", i), rsp_rdata, exp_rd);
            chk(rsp_wdrop == exp_wd, rq, $sformatf("vec%0d wdrop", i),
                {31'h0, rsp_wdrop}, {31'h0, exp_wd});
        end

        // R2: undefined bits read zero
        do_reset();
        reg_write(1'b0, 8'hF9);
        chk(ctl_q == 8'h01, "R2", "ctl mask", {24'h0, ctl_q}, 32'h01);
        reg_write(1'b1, 8'hFA);
        chk(ext_q == 8'h0A, "R2", "ext mask", {24'h0, ext_q}, 32'h0A);

        // R3: lock forces open low, then freezes both registers
        reg_write(1'b1, 8'h08);
        reg_write(1'b0, 8'h07);
        chk(ctl_q == 8'h06, "R3", "lock closes", {24'h0, ctl_q}, 32'h06);
        reg_write(1'b0, 8'h01);
        chk(ctl_q == 8'h06, "R3", "ctl frozen", {24'h0, ctl_q}, 32'h06);
        reg_write(1'b1, 8'h05);
        chk(ext_q == 8'h08, "R3", "ext frozen", {24'h0, ext_q}, 32'h08);
        access(1'b0, 1'b0, 32'hFEDA_0000);
        chk(rsp_tgt == 2'd0, "R5", "locked high closed", {30'h0, rsp_tgt}, 32'h0);
        access(1'b0, 1'b0, 32'h000A_0000);
        chk(rsp_tgt == 2'd1, "R4", "locked low video", {30'h0, rsp_tgt}, 32'h1);
        access(1'b0, 1'b1, 32'h7FFF_FFFF);
        chk(rsp_tgt == 2'd0 && !rsp_wdrop, "R8", "no tseg locked off",
            {29'h0, rsp_wdrop, rsp_tgt}, 32'h0);

        // R1: only reset clears lock
        do_reset();
        chk(ctl_q == 8'h00, "R1", "lock cleared by reset", {24'h0, ctl_q}, 32'h0);
        chk(ext_q == 8'h00, "R1", "ext cleared by reset", {24'h0, ext_q}, 32'h0);
        reg_write(1'b0, 8'h01);
        chk(ctl_q == 8'h01, "R1", "writable after reset", {24'h0, ctl_q}, 32'h01);

        // R9: response drops after one cycle
        access(1'b1, 1'b0, 32'h1234_5678);
        chk(rsp_addr == 32'h1234_5678, "R9", "pass addr", rsp_addr, 32'h1234_5678);
        @(negedge clk);
        chk(rsp_vld == 1'b0, "R9", "vld one cycle", {31'h0, rsp_vld}, 32'h0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule